// File: doc/BRIEF.md
# Flag-Stepped I2C Bus Master

This block drives an I2C bus as a single master under the command of a host processor. The host reaches it through four byte-wide registers: control, data, status and clock divider. The host asks for a bus event by setting control bits. The block carries out one bus step at a time. After each step it raises an interrupt flag, posts a one-byte status code and holds SCL low until the host clears the flag.

The steps are START, repeated START, a transmitted byte, a received byte and STOP. A transmitted byte is either the address byte, with the slave address in bits [7:1] and the direction in bit 0, or a write data byte. For a received byte, the host chooses in advance whether the block answers it with ACK or NACK. A START waits until the bus is free. While the block sends a one, it watches SDA so that it can give up the bus to another master.

Both bus lines are open-drain. Each is modelled as a drive-low enable plus the sampled line level. Each bit takes four quarter periods, and each quarter lasts (divider + 1) clock cycles.

Top module: `i2c_step_master`

## Requirements
- R1: After reset the status register reads F8h, the control register reads 00h, `irq` is low and both drive-low enables are off.
- R2: Writing control bit 0 (start request) on a free bus produces a START (SDA falls while SCL is high), then sets the flag (control bit 2, `irq`) with status 08h and clears the start request.
- R3: While the bus is busy, meaning a START has been seen and no STOP after it, a start request produces no bus activity and no flag. The START follows once a STOP has been seen.
- R4: While the flag is set, SCL stays driven low and the status holds its value. Writing control with bit 2 at 0 clears the flag and starts the next step.
- R5: An address byte with bit 0 at 1 (read) posts 40h when the slave acknowledges it and 48h when it does not.
- R6: A received byte is shifted in MSB first and placed in the data register. The block answers it with ACK and posts 50h when control bit 3 was 1 in the write that cleared the flag. It answers with NACK and posts 58h when that bit was 0.
- R7: A start request made while the flag is cleared in the middle of a transfer produces a repeated START and posts 10h.
- R8: Control bit 1 (stop request) produces a STOP. The block then clears that bit, sets no flag, releases both lines and shows status F8h.
- R9: Setting the start and stop requests together produces a STOP followed by a new START, which posts 08h.
- R10: When the block releases SDA during a transmitted bit and samples SDA low, it stops driving both lines and posts 38h. Clearing the flag afterwards returns it to idle with status F8h.
- R11: An address byte with bit 0 at 0 (write) posts 18h when it is acknowledged. A data byte written after it is sent MSB first and posts 28h when it is acknowledged.
- R12: Each SCL high phase inside a byte lasts 2*(D+1) clock cycles, where D is the value of the divider register (address 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_waddr | input | 2 | Write address: 0 control, 1 data, 3 divider |
| host_wdata | input | 8 | Write data |
| host_raddr | input | 2 | Read address: 0 control, 1 data, 2 status, 3 divider |
| host_rdata | output | 8 | Read data, combinational from `host_raddr` |
| irq | output | 1 | Flag: a bus step has completed |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Drive SCL low |
| sda_oe | output | 1 | Drive SDA low |

## Verification
A step's status code and received byte are registered on the same edge that raises `irq`. The monitor therefore picks them up at the first falling clock edge where `irq` is seen high after being low, and pops the expected item that the driver queued before it started the step. A STOP sets no flag, so the driver polls the control register until the stop request bit drops, and only then checks the status and the line levels. A START costs two quarters, a repeated START three, a STOP three and a byte 36, all of (D+1) cycles each. Every wait is bounded by a cycle limit derived from these figures, so a step that never completes is reported as a failure.

// File: rtl/i2c_step_master.sv
module i2c_step_master #(
  parameter logic [7:0] DIV_RESET = 8'd4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [1:0] host_waddr,
  input  logic [7:0] host_wdata,
  input  logic [1:0] host_raddr,
  output logic [7:0] host_rdata,
  output logic       irq,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam logic [7:0] ST_IDLE = 8'hF8;

  typedef enum logic [2:0] {S_IDLE, S_START, S_RSTART, S_XFER, S_WAIT, S_STOP} st_t;
  st_t st;

  logic sta, stp, iflg, aak, ack_q, busy, lost, addr_ph, rd_mode;
  logic scl_d, sda_d;
  logic [7:0] data_q, stat_q, sh, div_q, cnt;
  logic [1:0] qc;
  logic [3:0] bitn;

  wire active     = (st == S_START) || (st == S_RSTART) || (st == S_XFER) || (st == S_STOP);
  wire tick       = active && (cnt == 8'd0);
  wire tx_dir     = addr_ph || !rd_mode;
  wire start_seen = scl_i && scl_d && sda_d && !sda_i;
  wire stop_seen  = scl_i && scl_d && !sda_d && sda_i;

  assign irq = iflg;

  always_comb begin
    case (host_raddr)
      2'd0:    host_rdata = {4'b0, aak, iflg, stp, sta};
      2'd1:    host_rdata = data_q;
      2'd2:    host_rdata = stat_q;
      default: host_rdata = div_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
      if (start_seen)     busy <= 1'b1;
      else if (stop_seen) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sta <= 1'b0; stp <= 1'b0; iflg <= 1'b0; aak <= 1'b0; ack_q <= 1'b0;
      lost <= 1'b0; addr_ph <= 1'b0; rd_mode <= 1'b0;
      data_q <= 8'h00; stat_q <= ST_IDLE; sh <= 8'h00;
      div_q <= DIV_RESET; cnt <= 8'h00; qc <= 2'd0; bitn <= 4'd0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (host_we) begin
        case (host_waddr)
          2'd0: begin
            sta <= host_wdata[0];
            stp <= host_wdata[1];
            aak <= host_wdata[3];
            if (iflg && !host_wdata[2]) begin
              iflg  <= 1'b0;
              ack_q <= host_wdata[3];
            end
          end
          2'd1:    data_q <= host_wdata;
          2'd3:    div_q  <= host_wdata;
          default: ;
        endcase
      end

      if (active) cnt <= tick ? div_q : cnt - 8'd1;

      case (st)
        S_IDLE: begin
          if (sta && !busy && scl_i && sda_i) begin
            st <= S_START; sda_oe <= 1'b1; qc <= 2'd0; cnt <= div_q;
          end
        end
        S_START: if (tick) begin
          qc <= qc + 2'd1;
          if (qc == 2'd1) begin
            scl_oe <= 1'b1; sta <= 1'b0; addr_ph <= 1'b1;
            iflg <= 1'b1; stat_q <= 8'h08; st <= S_WAIT;
          end
        end
        S_RSTART: if (tick) begin
          qc <= qc + 2'd1;
          case (qc)
            2'd0: scl_oe <= 1'b0;
            2'd1: sda_oe <= 1'b1;
            default: begin
              scl_oe <= 1'b1; sta <= 1'b0; addr_ph <= 1'b1;
              iflg <= 1'b1; stat_q <= 8'h10; st <= S_WAIT;
            end
          endcase
        end
        S_STOP: if (tick) begin
          qc <= qc + 2'd1;
          case (qc)
            2'd0: scl_oe <= 1'b0;
            2'd1: sda_oe <= 1'b0;
            default: begin
              stp <= 1'b0; stat_q <= ST_IDLE; st <= S_IDLE;
            end
          endcase
        end
        S_WAIT: begin
          if (!iflg) begin
            qc  <= 2'd0;
            cnt <= div_q;
            if (lost) begin
              lost <= 1'b0; stat_q <= ST_IDLE; st <= S_IDLE;
            end else if (stp) begin
              sda_oe <= 1'b1; st <= S_STOP;
            end else if (sta) begin
              sda_oe <= 1'b0; st <= S_RSTART;
            end else begin
              bitn <= 4'd0; sh <= data_q; st <= S_XFER;
              if (addr_ph) rd_mode <= data_q[0];
            end
          end
        end
        S_XFER: if (tick) begin
          qc <= qc + 2'd1;
          case (qc)
            2'd0: begin
              if (bitn < 4'd8) sda_oe <= tx_dir ? !sh[7] : 1'b0;
              else             sda_oe <= tx_dir ? 1'b0 : ack_q;
            end
            2'd1: scl_oe <= 1'b0;
            2'd2: ;
            default: begin
              scl_oe <= 1'b1;
              if (bitn < 4'd8) begin
                if (tx_dir && !sda_oe && !sda_i) begin
                  lost <= 1'b1; scl_oe <= 1'b0; sda_oe <= 1'b0; addr_ph <= 1'b0;
                  iflg <= 1'b1; stat_q <= 8'h38; st <= S_WAIT;
                end else begin
                  sh   <= {sh[6:0], sda_i};
                  bitn <= bitn + 4'd1;
                end
              end else begin
                iflg <= 1'b1; st <= S_WAIT; addr_ph <= 1'b0;
                if (addr_ph)
                  stat_q <= rd_mode ? (sda_i ? 8'h48 : 8'h40) : (sda_i ? 8'h20 : 8'h18);
                else if (rd_mode) begin
                  stat_q <= ack_q ? 8'h50 : 8'h58;
                  data_q <= sh;
                end else
                  stat_q <= sda_i ? 8'h30 : 8'h28;
              end
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_start_holds_lines: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(iflg) && stat_q == 8'h08) |-> (scl_oe && sda_oe));
  a_r3_busy_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && busy) |=> (st == S_IDLE));
  a_r4_stall_lines_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg && $past(iflg) && !lost) |-> ($stable(scl_oe) && $stable(sda_oe) && scl_oe));
  a_r6_ack_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(iflg) && stat_q == 8'h50) |-> $past(sda_oe));
  a_r6_nack_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(iflg) && stat_q == 8'h58) |-> !$past(sda_oe));
  a_r8_stop_ends_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_STOP && st == S_IDLE) |-> (!stp && !iflg && !scl_oe && !sda_oe));
  a_r10_lost_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg && stat_q == 8'h38) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/tb_i2c_step_master.sv
`timescale 1ns/1ps
module tb_i2c_step_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [1:0] host_waddr = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [1:0] host_raddr = 2'd1;
  logic [7:0] host_rdata;
  logic irq, scl_oe, sda_oe;
  logic slv_oe = 1'b0;
  logic rogue_oe = 1'b0;

  always #10 clk = ~clk;

  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || slv_oe || rogue_oe);

  i2c_step_master dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .irq(irq), .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe));

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model, 7-bit address 0x50, sends A5, A6, ... when read
  localparam logic [6:0] SLV_ADDR = 7'h50;
  bit pre = 1'b1, is_addr = 1'b1, sel = 1'b0, rd = 1'b0;
  int bc = 0;
  logic [7:0] rx = 8'h00, tx = 8'hA5, got_wr = 8'h00;
  int starts = 0;

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    pre = 1'b1; is_addr = 1'b1; sel = 1'b0; bc = 0; slv_oe = 1'b0; starts++;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) begin
    pre = 1'b1; sel = 1'b0; slv_oe = 1'b0;
  end
  always @(negedge scl_w) begin
    if (pre) begin pre = 1'b0; bc = 0; end
    else if (bc == 8) begin bc = 0; is_addr = 1'b0; end
    else bc++;
    slv_oe = 1'b0;
    if (sel) begin
      if (bc == 8 && (is_addr || !rd)) slv_oe = 1'b1;
      else if (bc < 8 && rd && !is_addr) slv_oe = !tx[7-bc];
    end
  end
  always @(posedge scl_w) begin
    if (bc < 8) rx = {rx[6:0], sda_w};
    if (bc == 7 && is_addr) begin sel = (rx[7:1] == SLV_ADDR); rd = rx[0]; end
    if (bc == 7 && !is_addr && sel && !rd) got_wr = rx;
    if (bc == 8 && sel && rd && !is_addr) begin
      if (sda_w) sel = 1'b0;
      tx = tx + 8'd1;
    end
  end

  // SCL high-run measurement
  int run = 0, last_run = 0;
  always @(negedge clk) begin
    if (scl_w) run++;
    else begin
      if (run > 0) last_run = run;
      run = 0;
    end
  end

  // scoreboard
  typedef struct {
    logic [7:0] st;
    logic [7:0] dat;
    bit         chk;
    string      req;
  } item_t;
  item_t sbq[$];
  logic irq_d = 1'b0;

  always @(negedge clk) begin
    if (rst_n && irq && !irq_d) begin
      logic [7:0] s, d;
      item_t it;
      host_raddr = 2'd2; #1 s = host_rdata;
      host_raddr = 2'd1; #1 d = host_rdata;
      if (sbq.size() == 0) check(1'b0, "unexpected flag", s, 0);
      else begin
        it = sbq.pop_front();
        check(s == it.st, it.req, s, it.st);
        if (it.chk) check(d == it.dat, {it.req, " data"}, d, it.dat);
      end
    end
    irq_d = irq;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    #3 host_raddr = a;
    #1 d = host_rdata;
    host_raddr = 2'd1;
  endtask

  task automatic push(input logic [7:0] s, input logic [7:0] d, input bit c, input string r);
    item_t it;
    it.st = s; it.dat = d; it.chk = c; it.req = r;
    sbq.push_back(it);
  endtask

  task automatic wait_sb(input string r);
    int n = 0;
    while (sbq.size() != 0 && n < 4000) begin @(negedge clk); n++; end
    check(sbq.size() == 0, {r, " step timeout"}, sbq.size(), 0);
    sbq.delete();
    repeat (2) @(negedge clk);
  endtask

  // control value: flag cleared, with ack/stop/start bits
  function automatic logic [7:0] ctl(input bit a, input bit p, input bit s);
    return {4'b0, a, 1'b0, p, s};
  endfunction

  task automatic do_stop(input string r);
    logic [7:0] v;
    int n = 0;
    wr(2'd0, ctl(0, 1, 0));
    do begin rdreg(2'd0, v); n++; end while (v[1] && n < 2000);
    check(v[1] == 1'b0, {r, " stop bit cleared"}, v, 0);
    rdreg(2'd2, v);
    check(v == 8'hF8, {r, " idle status"}, v, 8'hF8);
    check(irq == 1'b0 && scl_w && sda_w, {r, " lines released"}, {irq, scl_w, sda_w}, 3'b011);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int s0;
    repeat (3) @(negedge clk);
    // R1 reset state
    rdreg(2'd2, v); check(v == 8'hF8, "R1 status", v, 8'hF8);
    rdreg(2'd0, v); check(v == 8'h00, "R1 control", v, 8'h00);
    check(!irq && !scl_oe && !sda_oe, "R1 outputs", {irq, scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 start
    s0 = starts;
    wr(2'd1, 8'hA0);
    push(8'h08, 0, 0, "R2 start");
    wr(2'd0, 8'h01);
    wait_sb("R2");
    check(starts == s0 + 1, "R2 start condition seen", starts, s0 + 1);
    rdreg(2'd0, v); check(v[0] == 1'b0, "R2 start bit cleared", v, 0);

    // R4 stall
    repeat (200) @(negedge clk);
    check(scl_w == 1'b0 && irq, "R4 SCL held low", scl_w, 0);
    rdreg(2'd2, v); check(v == 8'h08, "R4 status holds", v, 8'h08);

    // R11 write address, R12 divider 4
    push(8'h18, 0, 0, "R11 write addr");
    wr(2'd0, ctl(0, 0, 0));
    wait_sb("R11");
    check(last_run == 10, "R12 high time D=4", last_run, 10);
    wr(2'd1, 8'h3C);
    push(8'h28, 0, 0, "R11 write data");
    wr(2'd0, ctl(0, 0, 0));
    wait_sb("R11");
    check(got_wr == 8'h3C, "R11 byte at slave", got_wr, 8'h3C);

    // R7 repeated start
    s0 = starts;
    push(8'h10, 0, 0, "R7 repeated start");
    wr(2'd0, ctl(0, 0, 1));
    wait_sb("R7");
    check(starts == s0 + 1, "R7 start condition seen", starts, s0 + 1);

    // R5 read address acked, R6 receive
    wr(2'd1, 8'hA1);
    push(8'h40, 0, 0, "R5 read addr ack");
    wr(2'd0, ctl(1, 0, 0));
    wait_sb("R5");
    push(8'h50, 8'hA5, 1, "R6 byte with ACK");
    wr(2'd0, ctl(1, 0, 0));
    wait_sb("R6");
    push(8'h58, 8'hA6, 1, "R6 byte with NACK");
    wr(2'd0, ctl(0, 0, 0));
    wait_sb("R6");

    // R8 stop
    do_stop("R8");

    // R5 address not acked
    wr(2'd1, 8'hEF);
    push(8'h08, 0, 0, "R5 start");
    wr(2'd0, 8'h01);
    wait_sb("R5");
    push(8'h48, 0, 0, "R5 read addr nack");
    wr(2'd0, ctl(0, 0, 0));
    wait_sb("R5");

    // R9 stop then start
    s0 = starts;
    push(8'h08, 0, 0, "R9 stop then start");
    wr(2'd0, ctl(0, 1, 1));
    wait_sb("R9");
    check(starts == s0 + 1, "R9 new start seen", starts, s0 + 1);
    rdreg(2'd0, v); check(v[1:0] == 2'b00, "R9 requests cleared", v[1:0], 0);
    wr(2'd1, 8'hA1);
    push(8'h40, 0, 0, "R9 read addr");
    wr(2'd0, ctl(0, 0, 0));
    wait_sb("R9");
    push(8'h58, 8'hA7, 1, "R6 single byte NACK");
    wr(2'd0, ctl(0, 0, 0));
    wait_sb("R6");
    do_stop("R8 second");

    // R3 busy bus
    rogue_oe = 1'b1;
    repeat (5) @(negedge clk);
    wr(2'd0, 8'h01);
    repeat (300) @(negedge clk);
    check(!irq && !scl_oe && !sda_oe, "R3 no activity while busy", {irq, scl_oe, sda_oe}, 0);
    rdreg(2'd2, v); check(v == 8'hF8, "R3 status idle", v, 8'hF8);
    push(8'h08, 0, 0, "R3 start after stop");
    rogue_oe = 1'b0;
    wait_sb("R3");

    // R10 arbitration loss
    rogue_oe = 1'b1;
    wr(2'd1, 8'hA0);
    push(8'h38, 0, 0, "R10 lost");
    wr(2'd0, ctl(0, 0, 0));
    wait_sb("R10");
    check(!scl_oe && !sda_oe && scl_w, "R10 lines released", {scl_oe, sda_oe}, 0);
    rogue_oe = 1'b0;
    repeat (5) @(negedge clk);
    wr(2'd0, ctl(0, 0, 0));
    repeat (5) @(negedge clk);
    rdreg(2'd2, v); check(v == 8'hF8, "R10 back to idle", v, 8'hF8);
    check(!irq, "R10 flag clear", irq, 0);

    // R12 divider 1
    wr(2'd3, 8'd1);
    push(8'h08, 0, 0, "R12 start");
    wr(2'd0, 8'h01);
    wait_sb("R12");
    push(8'h18, 0, 0, "R12 addr");
    wr(2'd0, ctl(0, 0, 0));
    wait_sb("R12");
    check(last_run == 4, "R12 high time D=1", last_run, 4);
    do_stop("R12 stop");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule